// File: doc/BRIEF.md
# Triggered Event Capture Controller

This block governs event capture for a multichannel front end while an acquisition window is open. Every channel drives a discriminator hit line. An external trigger line and a validation enable come in from outside the chip. Any hit, or the external trigger, starts an event. The block then waits a programmable hold delay and pulses a hold strobe so that the analog samples are frozen near the shaper peak. At the same time it writes one column into a per-channel event memory. The column holds a hit-flag vector, the lowest-numbered channel that started the event, a timestamp taken from a free-running bunch counter, and a gain bit.

Only one event can be in progress at a time. Hits that arrive while an event is pending are lost. When validation is enabled, an event started by a channel hit is kept only if an external trigger arrives within a programmable coincidence window. A rejected event still produces its hold strobe but does not use up a memory slot. After the memory holds its full count of events, a full flag rises and further triggers are ignored until the window closes.

Stored events leave through a valid/ready stream in the order they were stored. While `rd_valid` is high and `rd_ready` is low, the output word is held unchanged. Reading an event does not free its slot for the current window. Opening a new window empties the memory.

Top module: `evt_capture_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `hold_strobe`, `rd_valid` and `mem_full` are low.
- R2: A trigger is accepted only in a cycle where `acq_en` is high and was also high in the previous cycle. Hits or `ext_trig` while `acq_en` is low, or in the first cycle of a window, produce no strobe and no stored event.
- R3: An accepted hit-started event in cycle T stores the following values: the flags equal `hit_in` in cycle T; the lead field equals the lowest set channel index in T; the timestamp equals the bunch counter in T; the gain equals `gain_sel` in T. The bunch counter is 0 in the first cycle after reset and adds one every cycle, wrapping at its width.
- R4: For a trigger accepted in cycle T, `hold_strobe` is high for exactly one cycle, cycle T+1+`hold_dly`.
- R5: Hits and triggers in cycles T+1 through T+1+`hold_dly` are lost. A new trigger can be accepted from cycle T+2+`hold_dly` onward.
- R6: An event whose start cycle has `ext_trig` high stores all flags set and a lead field equal to the channel count (36), whether or not hits are present.
- R7: If `validate_en` is high in the start cycle of a hit-started event, the event is stored only if `ext_trig` is high in some cycle T+k+1 with k < `coin_win` and k ≤ `hold_dly`. Otherwise the hold strobe still fires, nothing is stored, and the slot stays free. Externally started events are always stored.
- R8: After DEPTH (16) events are stored, `mem_full` rises in the next cycle and further triggers produce no strobe. `mem_full` stays high while `acq_en` stays high, and it is low in the cycle after `acq_en` is low.
- R9: The first cycle of a new window empties the memory, and `rd_valid` is low in the cycle after it.
- R10: Events leave in storage order, one for each cycle in which `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the output word is held stable. Reading does not free slots.
- R11: If `acq_en` falls while an event is pending, the event is dropped and no hold strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition window level |
| hit_in | input | 36 | Discriminator hits, one per channel |
| ext_trig | input | 1 | External trigger |
| validate_en | input | 1 | Requires external coincidence for hit-started events |
| gain_sel | input | 1 | Gain bit recorded with each event |
| hold_dly | input | 8 | Cycles between trigger and hold strobe, minus one |
| coin_win | input | 4 | Coincidence window length in cycles |
| hold_strobe | output | 1 | One-cycle sample hold pulse |
| mem_full | output | 1 | Event memory full in this window |
| rd_valid | output | 1 | Stored event available |
| rd_ready | input | 1 | Consumer accepts the current event |
| rd_hits | output | 36 | Event hit flags |
| rd_lead | output | 6 | Lowest channel that started the event, or 36 for an external event |
| rd_ts | output | 12 | Event timestamp |
| rd_gain | output | 1 | Event gain bit |

## Verification
The bench drives noise on every channel during the whole busy period. A design that re-armed early, or that let late hits into the flags, would then store extra columns or corrupted flags. For validation, the external pulse is placed just inside and just outside the coincidence window, and on the hold cycle itself. An off-by-one in the window would then either keep a rejected event or drop a good one, which shows up as a misaligned readout. The bench also fills the memory with unread data, closes the window in the middle of an event, and reopens a window over unread events. A design that handled these wrongly would strobe after the window closed, leave `mem_full` stuck, or replay stale columns. Readout runs with an irregular ready pattern, so any word that changes during a stall is caught.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [0:0] {SEQ_IDLE, SEQ_WAIT} seq_state_e;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/evt_window_ctl.sv
module evt_window_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_en,
  input  logic fill_evt,
  output logic acq_prev,
  output logic acq_rise,
  output logic acq_open,
  output logic full
);
  logic acq_q;
  logic full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      acq_q <= acq_en;
      if (!acq_en)
        full_q <= 1'b0;
      else if (fill_evt)
        full_q <= 1'b1;
    end
  end

  assign acq_prev = acq_q;
  assign acq_rise = acq_en & ~acq_q;
  assign acq_open = acq_en & acq_q;
  assign full     = full_q;
endmodule

// File: rtl/evt_trig_seq.sv
module evt_trig_seq #(
  parameter int NCH   = 36,
  parameter int TSW   = 12,
  parameter int HOLDW = 8,
  parameter int COINW = 4,
  parameter int IDXW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_en,
  input  logic             acq_open,
  input  logic             full,
  input  logic [NCH-1:0]   hit_in,
  input  logic             ext_trig,
  input  logic             validate_en,
  input  logic             gain_sel,
  input  logic [HOLDW-1:0] hold_dly,
  input  logic [COINW-1:0] coin_win,
  input  logic [TSW-1:0]   ts_now,
  output logic             hold_strobe,
  output logic             wr_en,
  output logic [NCH-1:0]   wr_hits,
  output logic [IDXW-1:0]  wr_lead,
  output logic [TSW-1:0]   wr_ts,
  output logic             wr_gain
);
  import evt_pkg::*;

  localparam int CNTW = max_w(HOLDW, COINW);

  seq_state_e       state;
  logic [CNTW-1:0]  cnt;
  logic [NCH-1:0]   ev_hits;
  logic [IDXW-1:0]  ev_lead;
  logic [TSW-1:0]   ev_ts;
  logic             ev_gain;
  logic             ev_ok;
  logic [IDXW-1:0]  lead_idx;
  logic             start;
  logic             at_hold;
  logic             coin_hit;

  // lowest-index channel among the hits; NCH when none
  always_comb begin
    lead_idx = IDXW'(NCH);
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit_in[i]) lead_idx = IDXW'(i);
    end
  end

  assign start    = (state == SEQ_IDLE) && acq_open && !full && (ext_trig || (|hit_in));
  assign at_hold  = (cnt == CNTW'(hold_dly));
  assign coin_hit = ext_trig && (cnt < CNTW'(coin_win));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cnt     <= '0;
      ev_hits <= '0;
      ev_lead <= '0;
      ev_ts   <= '0;
      ev_gain <= 1'b0;
      ev_ok   <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state   <= SEQ_WAIT;
            cnt     <= '0;
            ev_hits <= ext_trig ? '1 : hit_in;
            ev_lead <= ext_trig ? IDXW'(NCH) : lead_idx;
            ev_ts   <= ts_now;
            ev_gain <= gain_sel;
            ev_ok   <= ext_trig || !validate_en;
          end
        end
        default: begin
          if (!acq_en || at_hold) begin
            state <= SEQ_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (coin_hit) ev_ok <= 1'b1;
          end
        end
      endcase
    end
  end

  assign hold_strobe = (state == SEQ_WAIT) && acq_en && at_hold;
  assign wr_en       = hold_strobe && (ev_ok || coin_hit);
  assign wr_hits     = ev_hits;
  assign wr_lead     = ev_lead;
  assign wr_ts       = ev_ts;
  assign wr_gain     = ev_gain;
endmodule

// File: rtl/evt_col_store.sv
module evt_col_store #(
  parameter int NCH   = 36,
  parameter int DEPTH = 16,
  parameter int TSW   = 12,
  parameter int IDXW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [NCH-1:0]  wr_hits,
  input  logic [IDXW-1:0] wr_lead,
  input  logic [TSW-1:0]  wr_ts,
  input  logic            wr_gain,
  output logic            fill_evt,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [NCH-1:0]  rd_hits,
  output logic [IDXW-1:0] rd_lead,
  output logic [TSW-1:0]  rd_ts,
  output logic            rd_gain
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [NCH-1:0]  hits_m [DEPTH];
  logic [IDXW-1:0] lead_m [DEPTH];
  logic [TSW-1:0]  ts_m   [DEPTH];
  logic [DEPTH-1:0] gain_m;
  logic [CW-1:0]   wr_cnt;
  logic [CW-1:0]   rd_ptr;
  logic            wr_ok;

  assign wr_ok    = wr_en && (wr_cnt < CW'(DEPTH));
  assign fill_evt = wr_ok && (wr_cnt == CW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_cnt <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_ok) wr_cnt <= wr_cnt + 1'b1;
      if (rd_valid && rd_ready) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_col
    always_ff @(posedge clk) begin
      if (wr_ok && (wr_cnt == CW'(g))) begin
        hits_m[g] <= wr_hits;
        lead_m[g] <= wr_lead;
        ts_m[g]   <= wr_ts;
        gain_m[g] <= wr_gain;
      end
    end
  end

  assign rd_valid = (rd_ptr < wr_cnt);
  assign rd_hits  = hits_m[AW'(rd_ptr)];
  assign rd_lead  = lead_m[AW'(rd_ptr)];
  assign rd_ts    = ts_m[AW'(rd_ptr)];
  assign rd_gain  = gain_m[AW'(rd_ptr)];
endmodule

// File: rtl/evt_capture_ctrl.sv
module evt_capture_ctrl #(
  parameter int NCH   = 36,
  parameter int DEPTH = 16,
  parameter int TSW   = 12,
  parameter int HOLDW = 8,
  parameter int COINW = 4,
  parameter int IDXW  = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_en,
  input  logic [NCH-1:0]   hit_in,
  input  logic             ext_trig,
  input  logic             validate_en,
  input  logic             gain_sel,
  input  logic [HOLDW-1:0] hold_dly,
  input  logic [COINW-1:0] coin_win,
  output logic             hold_strobe,
  output logic             mem_full,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [NCH-1:0]   rd_hits,
  output logic [IDXW-1:0]  rd_lead,
  output logic [TSW-1:0]   rd_ts,
  output logic             rd_gain
);
  logic           acq_prev;
  logic           acq_rise;
  logic           acq_open;
  logic           full;
  logic           fill_evt;
  logic           wr_en;
  logic [NCH-1:0] wr_hits;
  logic [IDXW-1:0] wr_lead;
  logic [TSW-1:0] wr_ts;
  logic           wr_gain;
  logic [TSW-1:0] bunch_ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bunch_ctr <= '0;
    else        bunch_ctr <= bunch_ctr + 1'b1;
  end

  evt_window_ctl u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .acq_en   (acq_en),
    .fill_evt (fill_evt),
    .acq_prev (acq_prev),
    .acq_rise (acq_rise),
    .acq_open (acq_open),
    .full     (full)
  );

  evt_trig_seq #(
    .NCH(NCH), .TSW(TSW), .HOLDW(HOLDW), .COINW(COINW), .IDXW(IDXW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_en      (acq_en),
    .acq_open    (acq_open),
    .full        (full),
    .hit_in      (hit_in),
    .ext_trig    (ext_trig),
    .validate_en (validate_en),
    .gain_sel    (gain_sel),
    .hold_dly    (hold_dly),
    .coin_win    (coin_win),
    .ts_now      (bunch_ctr),
    .hold_strobe (hold_strobe),
    .wr_en       (wr_en),
    .wr_hits     (wr_hits),
    .wr_lead     (wr_lead),
    .wr_ts       (wr_ts),
    .wr_gain     (wr_gain)
  );

  evt_col_store #(
    .NCH(NCH), .DEPTH(DEPTH), .TSW(TSW), .IDXW(IDXW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (acq_rise),
    .wr_en    (wr_en),
    .wr_hits  (wr_hits),
    .wr_lead  (wr_lead),
    .wr_ts    (wr_ts),
    .wr_gain  (wr_gain),
    .fill_evt (fill_evt),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_hits  (rd_hits),
    .rd_lead  (rd_lead),
    .rd_ts    (rd_ts),
    .rd_gain  (rd_gain)
  );

  assign mem_full = full;
endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk #(
  parameter int NCH  = 36,
  parameter int TSW  = 12,
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acq_en,
  input logic            acq_prev,
  input logic            hold_strobe,
  input logic            mem_full,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [NCH-1:0]  rd_hits,
  input logic [IDXW-1:0] rd_lead,
  input logic [TSW-1:0]  rd_ts,
  input logic            rd_gain
);
  // R4
  hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_strobe |=> !hold_strobe);

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |-> !hold_strobe);

  // R8
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full && acq_en) |=> mem_full);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> !mem_full);

  // R11
  closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |-> !hold_strobe);

  // R9
  open_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && !acq_prev) |=> !rd_valid);

  // R10
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !(acq_en && !acq_prev)) |=>
      (rd_valid && $stable(rd_hits) && $stable(rd_lead) && $stable(rd_ts) && $stable(rd_gain)));

  // R3
  lead_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_lead <= IDXW'(NCH)));
endmodule

bind evt_capture_ctrl evt_capture_chk #(.NCH(NCH), .TSW(TSW), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acq_en      (acq_en),
  .acq_prev    (acq_prev),
  .hold_strobe (hold_strobe),
  .mem_full    (mem_full),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_hits     (rd_hits),
  .rd_lead     (rd_lead),
  .rd_ts       (rd_ts),
  .rd_gain     (rd_gain)
);

// File: tb/tb_evt_capture_ctrl.sv
module tb_evt_capture_ctrl;
  localparam int NCH = 36, DEPTH = 16, TSW = 12, HOLDW = 8, COINW = 4, IDXW = 6;

  typedef struct packed {
    logic [NCH-1:0]  hits;
    logic [IDXW-1:0] lead;
    logic [TSW-1:0]  ts;
    logic            gain;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_en = 1'b0;
  logic [NCH-1:0] hit_in = '0;
  logic ext_trig = 1'b0;
  logic validate_en = 1'b0;
  logic gain_sel = 1'b0;
  logic [HOLDW-1:0] hold_dly = 8'd2;
  logic [COINW-1:0] coin_win = 4'd3;
  logic rd_ready = 1'b0;
  logic hold_strobe, mem_full, rd_valid, rd_gain;
  logic [NCH-1:0] rd_hits;
  logic [IDXW-1:0] rd_lead;
  logic [TSW-1:0] rd_ts;

  int n_chk = 0;
  int n_bad = 0;
  int bc = 0;
  bit stall_watch = 0;
  ev_t exp_q[$];

  always #2 clk = ~clk;

  evt_capture_ctrl dut (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .hit_in(hit_in), .ext_trig(ext_trig),
    .validate_en(validate_en), .gain_sel(gain_sel), .hold_dly(hold_dly), .coin_win(coin_win),
    .hold_strobe(hold_strobe), .mem_full(mem_full), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_hits(rd_hits), .rd_lead(rd_lead), .rd_ts(rd_ts), .rd_gain(rd_gain)
  );

  always @(posedge clk) if (rst_n) bc <= bc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [IDXW-1:0] lowest(input logic [NCH-1:0] h);
    lowest = IDXW'(NCH);
    for (int i = NCH - 1; i >= 0; i--) if (h[i]) lowest = IDXW'(i);
  endfunction

  // monitor: pops the scoreboard on each handshake
  initial begin
    ev_t held;
    bit held_v = 0;
    forever begin
      ev_t cur;
      @(negedge clk);
      #1;
      cur = {rd_hits, rd_lead, rd_ts, rd_gain};
      if (held_v) chk(rd_valid && (cur == held), "R10", "word changed during stall", 64'(cur), 64'(held));
      held_v = 0;
      if (rst_n && rd_valid && rd_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected event", 64'(cur), 64'd0);
        else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(cur == e, "R3", "event content", 64'(cur), 64'(e));
        end
      end else if (rst_n && stall_watch && rd_valid && !rd_ready) begin
        held = cur;
        held_v = 1;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      hit_in = '0;
      ext_trig = 1'b0;
    end
  endtask

  task automatic fire(input logic [NCH-1:0] h, input bit ext, input bit g, input int d,
                      input int ext_at, input logic [NCH-1:0] noise,
                      input bit exp_strobe, input bit exp_store, input string req);
    ev_t e;
    @(negedge clk);
    hit_in = h; ext_trig = ext; gain_sel = g; hold_dly = HOLDW'(d);
    e.hits = ext ? '1 : h;
    e.lead = ext ? IDXW'(NCH) : lowest(h);
    e.ts   = bc[TSW-1:0];
    e.gain = g;
    for (int k = 0; k <= d; k++) begin
      @(negedge clk);
      hit_in = noise; ext_trig = (k == ext_at); gain_sel = ~g;
      #1;
      chk(hold_strobe == (exp_strobe && k == d), req, "hold strobe timing",
          64'(hold_strobe), 64'(exp_strobe && k == d));
    end
    if (exp_store) exp_q.push_back(e);
  endtask

  task automatic drain(input int pat);
    stall_watch = 1;
    for (int i = 0; i < 600 && exp_q.size() > 0; i++) begin
      @(negedge clk);
      rd_ready = (pat == 0) ? 1'b1 : ((i % 3) != 0);
    end
    @(negedge clk);
    rd_ready = 1'b0;
    stall_watch = 0;
    idle(2);
    #1;
    chk(!rd_valid && exp_q.size() == 0, "R10", "all events delivered", 64'(rd_valid), 64'd0);
  endtask

  task automatic open_window(input logic [NCH-1:0] h_rise);
    @(negedge clk);
    acq_en = 1'b1; hit_in = h_rise;
    exp_q.delete();
    @(negedge clk);
    hit_in = '0;
    #1;
    chk(!rd_valid, "R9", "memory empty after window opens", 64'(rd_valid), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!hold_strobe && !rd_valid && !mem_full, "R1", "outputs in reset",
        64'({hold_strobe, rd_valid, mem_full}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!hold_strobe && !rd_valid && !mem_full, "R1", "outputs after reset",
        64'({hold_strobe, rd_valid, mem_full}), 64'd0);

    // R2: window closed
    fire(36'h20, 1'b0, 1'b0, 2, -1, '0, 1'b0, 1'b0, "R2");
    fire(36'h0, 1'b1, 1'b0, 2, -1, '0, 1'b0, 1'b0, "R2");
    // R2: first cycle of window ignored
    open_window(36'h10);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(!hold_strobe, "R2", "no strobe from first window cycle", 64'(hold_strobe), 64'd0);
    end

    // R3 plain events, R4 delay variants
    fire(36'h140, 1'b0, 1'b1, 2, -1, '0, 1'b1, 1'b1, "R3");
    fire(36'h8_0000_0000, 1'b0, 1'b0, 0, -1, '0, 1'b1, 1'b1, "R4");
    fire(36'h0_0F00_0000, 1'b0, 1'b1, 7, -1, '0, 1'b1, 1'b1, "R4");
    // R5 busy noise lost, back-to-back accepted
    fire(36'h8, 1'b0, 1'b0, 3, -1, '1, 1'b1, 1'b1, "R5");
    fire(36'h10_0000, 1'b0, 1'b1, 3, -1, '0, 1'b1, 1'b1, "R5");
    // R6 external events
    fire(36'h4, 1'b1, 1'b0, 2, -1, '0, 1'b1, 1'b1, "R6");
    fire(36'h0, 1'b1, 1'b1, 1, -1, '0, 1'b1, 1'b1, "R6");
    // R7 validation
    validate_en = 1'b1; coin_win = 4'd2;
    fire(36'h2, 1'b0, 1'b0, 4, -1, '0, 1'b1, 1'b0, "R7");
    fire(36'h400, 1'b0, 1'b1, 4, 1, '0, 1'b1, 1'b1, "R7");
    fire(36'h800, 1'b0, 1'b0, 4, 2, '0, 1'b1, 1'b0, "R7");
    fire(36'h0, 1'b1, 1'b0, 4, -1, '0, 1'b1, 1'b1, "R7");
    coin_win = 4'd9;
    fire(36'h1, 1'b0, 1'b1, 2, 2, '0, 1'b1, 1'b1, "R7");
    validate_en = 1'b0;
    idle(2);
    drain(1);

    // R8 fill remaining slots (10 stored so far), reads did not free them
    for (int n = 0; n < 6; n++)
      fire(36'h1 << (n + 20), 1'b0, n[0], 1, -1, '0, 1'b1, 1'b1, "R8");
    @(negedge clk); #1;
    chk(mem_full, "R8", "full after sixteen events", 64'(mem_full), 64'd1);
    fire(36'h3, 1'b0, 1'b0, 1, -1, '0, 1'b0, 1'b0, "R8");
    fire(36'h0, 1'b1, 1'b0, 1, -1, '0, 1'b0, 1'b0, "R8");
    #1;
    chk(mem_full, "R8", "full holds in window", 64'(mem_full), 64'd1);
    drain(0);
    @(negedge clk); acq_en = 1'b0;
    @(negedge clk); #1;
    chk(!mem_full, "R8", "full clears after window end", 64'(mem_full), 64'd0);

    // R9 reopen over unread events
    open_window('0);
    fire(36'h100, 1'b0, 1'b0, 1, -1, '0, 1'b1, 1'b1, "R9");
    fire(36'h200, 1'b0, 1'b1, 1, -1, '0, 1'b1, 1'b1, "R9");
    idle(1); #1;
    chk(rd_valid, "R9", "unread events present", 64'(rd_valid), 64'd1);
    @(negedge clk); acq_en = 1'b0;
    open_window('0);
    fire(36'h4000, 1'b0, 1'b1, 1, -1, '0, 1'b1, 1'b1, "R9");
    drain(0);

    // R11 window closes during pending event
    @(negedge clk); hit_in = 36'h200; hold_dly = 8'd5;
    @(negedge clk); hit_in = '0;
    @(negedge clk); acq_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      chk(!hold_strobe && !rd_valid, "R11", "dropped pending event",
          64'({hold_strobe, rd_valid}), 64'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule